// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block keeps account of the cache requests that one processor port has in flight. Requests are split by class into two small associative tables keyed by cache-line address. Reads and instruction fetches go to one table; stores, read-modify-writes, load-linked, store-conditional, locked read-modify-writes and flushes go to the other. Every new request receives one answer: accepted, aliased (a request to the same line is already pending, so the requester must retry later), or full.

An entry is released when a completion for its line arrives on the read-side or write-side completion port. The two tables check each other, so a load never runs past a pending store to the same line and the reverse. Four counters record why a request aliased. A periodic watchdog raises a sticky deadlock flag when some entry has waited at least a set number of cycles. A sticky error flag reports a completion that matches no pending entry.

Top module: `inflight_line_tracker`

## Requirements
- R1: A request is answered full (status code 2) when the total outstanding count, taken after same-cycle completions, has reached MAX_OUT, or when the table of its class has no free entry; full takes priority over aliasing and records no alias count.
- R2: Class codes 0 (load) and 1 (instruction fetch) belong to the read table; codes 2 (store), 3 (read-modify-write), 4 (load-linked), 5 (store-conditional), 6 (locked read-modify-write) and 7 (flush) belong to the write table.
- R3: A write-class request is answered aliased (status 1) when its line is pending in the read table or in the write table.
- R4: A read-class request is answered aliased when its line is pending in the write table or in the read table.
- R5: Each alias raises exactly one of four counters: store-after-load, store-after-store, load-after-store or load-after-load. The opposite-class table is consulted first, so a request that matches both counts against the opposite class.
- R6: The lookup key is the address with its low OFF_W offset bits cleared. Two addresses in the same line alias, and neighbouring lines do not.
- R7: Each request is answered one cycle later on rsp_valid and rsp_status (0 accepted, 1 aliased, 2 full). No response appears without a request.
- R8: A completion whose line is pending frees that entry, and the lower outstanding count is visible one cycle later. The outstanding output always equals the number of occupied entries in both tables.
- R9: When a request and a completion arrive in the same cycle, the completion frees its entry first and the request is then judged against the updated tables and count.
- R10: A completion that matches no pending entry sets proto_err, which holds until reset, and changes no entry.
- R11: An accept while the watchdog is idle arms it. A check then runs every THRESH cycles while entries remain pending. A check that finds an entry aged THRESH or more sets deadlock, which holds until reset.
- R12: When every entry completes before a check falls due, deadlock stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request this cycle |
| req_kind | input | 3 | Request class code (see R2) |
| req_addr | input | ADDR_W | Request byte address |
| rd_done_valid | input | 1 | Read-side completion this cycle |
| rd_done_addr | input | ADDR_W | Address of the completed read |
| wr_done_valid | input | 1 | Write-side completion this cycle |
| wr_done_addr | input | ADDR_W | Address of the completed write |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_status | output | 2 | 0 accepted, 1 aliased, 2 full |
| outstanding | output | clog2(2*ENTRIES+1) | Occupied entries in both tables |
| deadlock | output | 1 | Sticky watchdog flag |
| proto_err | output | 1 | Sticky unmatched-completion flag |
| alias_st_ld | output | CNT_W | Store-after-load alias count |
| alias_st_st | output | CNT_W | Store-after-store alias count |
| alias_ld_st | output | CNT_W | Load-after-store alias count |
| alias_ld_ld | output | CNT_W | Load-after-load alias count |

## Verification
The bench sends request streams that each separate one cause from another. Same-line loads with different offsets show that the offset bits are masked. A load to the next line shows that distinct lines stay apart. Store-after-load, store-after-store and load-after-store requests each move one counter, which shows the cross-table priority. Filling the read table while the total is under the limit separates the table-full case from the count-limit case, and a store to a pending line at the limit shows that full outranks alias. A request that coincides with a completion, an unmatched completion and a reused freed line cover the release paths. Watchdog runs measure the exact edge at which deadlock rises, both for an entry that is still waiting and for one that was inserted after the first check missed it.

// File: rtl/trk_pkg.sv
package trk_pkg;

    typedef enum logic [2:0] {
        K_LOAD    = 3'd0,
        K_IFETCH  = 3'd1,
        K_STORE   = 3'd2,
        K_RMW     = 3'd3,
        K_LL      = 3'd4,
        K_SC      = 3'd5,
        K_LOCKRMW = 3'd6,
        K_FLUSH   = 3'd7
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_ACCEPT = 2'd0,
        RSP_ALIAS  = 2'd1,
        RSP_FULL   = 2'd2
    } rsp_code_e;

    // Codes 2..7 are write-table classes.
    function automatic logic kind_is_write(input logic [2:0] k);
        return (k >= 3'd2);
    endfunction

endpackage

// File: rtl/trk_table.sv
module trk_table #(
    parameter int N    = 4,
    parameter int LW   = 26,
    parameter int TW   = 7,
    localparam int IDXW = (N > 1) ? $clog2(N) : 1,
    localparam int TCW  = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        now_i,
    input  logic [LW-1:0]        look_line_i,
    output logic                 look_hit_o,
    input  logic                 free_valid_i,
    input  logic [LW-1:0]        free_line_i,
    output logic                 free_miss_o,
    input  logic                 alloc_i,
    output logic                 has_slot_o,
    output logic [TCW-1:0]       occ_o,
    output logic [TCW-1:0]       post_occ_o,
    output logic [N-1:0]         live_o,
    output logic [N-1:0][TW-1:0] stamp_o
);

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] tag;
        logic [TW-1:0] stamp;
    } ent_t;

    typedef struct packed {
        ent_t [N-1:0] ent;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic [N-1:0]    free_hit;
    logic [N-1:0]    live;
    logic [N-1:0]    look_match;
    logic [IDXW-1:0] slot;
    logic            slot_ok;
    logic [TCW-1:0]  occ;
    logic [TCW-1:0]  post_occ;

    always_comb begin
        st_d       = st_q;
        free_hit   = '0;
        live       = '0;
        look_match = '0;
        slot       = '0;
        slot_ok    = 1'b0;
        occ        = '0;
        post_occ   = '0;

        // Completion is applied before the lookup (same-cycle ordering).
        for (int i = 0; i < N; i++) begin
            free_hit[i]   = free_valid_i && st_q.ent[i].valid &&
                            (st_q.ent[i].tag == free_line_i);
            live[i]       = st_q.ent[i].valid && !free_hit[i];
            look_match[i] = live[i] && (st_q.ent[i].tag == look_line_i);
            occ           = occ + TCW'(st_q.ent[i].valid);
            post_occ      = post_occ + TCW'(live[i]);
        end

        // Lowest free index wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (!live[i]) begin
                slot    = i[IDXW-1:0];
                slot_ok = 1'b1;
            end
        end

        for (int i = 0; i < N; i++) begin
            if (free_hit[i]) begin
                st_d.ent[i].valid = 1'b0;
            end
        end

        if (alloc_i && slot_ok) begin
            st_d.ent[slot].valid = 1'b1;
            st_d.ent[slot].tag   = look_line_i;
            st_d.ent[slot].stamp = now_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign look_hit_o  = |look_match;
    assign free_miss_o = free_valid_i && !(|free_hit);
    assign has_slot_o  = slot_ok;
    assign occ_o       = occ;
    assign post_occ_o  = post_occ;
    assign live_o      = live;

    generate
        for (genvar g = 0; g < N; g++) begin : g_stamp
            assign stamp_o[g] = st_q.ent[g].stamp;
        end
    endgenerate

endmodule

// File: rtl/trk_watchdog.sv
module trk_watchdog #(
    parameter int M      = 8,
    parameter int TW     = 7,
    parameter int THRESH = 32,
    localparam int CNTW  = (THRESH > 2) ? $clog2(THRESH) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TW-1:0]        now_i,
    input  logic [M-1:0]         live_i,
    input  logic [M-1:0][TW-1:0] stamp_i,
    input  logic                 arm_i,
    input  logic                 busy_next_i,
    output logic                 deadlock_o
);

    localparam logic [CNTW-1:0] RELOAD = CNTW'(THRESH - 1);
    localparam logic [TW-1:0]   LIMIT  = TW'(THRESH);

    typedef struct packed {
        logic            armed;
        logic [CNTW-1:0] cnt;
        logic            dead;
    } wd_state_t;

    wd_state_t    st_d, st_q;
    logic [M-1:0] stale;

    always_comb begin
        st_d  = st_q;
        stale = '0;

        for (int i = 0; i < M; i++) begin
            logic [TW-1:0] age;
            age      = now_i - stamp_i[i];
            stale[i] = live_i[i] && (age >= LIMIT);
        end

        if (st_q.armed) begin
            if (st_q.cnt == '0) begin
                if (|stale) begin
                    st_d.dead = 1'b1;
                end
                st_d.armed = busy_next_i;
                st_d.cnt   = RELOAD;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (arm_i) begin
            st_d.armed = 1'b1;
            st_d.cnt   = RELOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign deadlock_o = st_q.dead;

endmodule

// File: rtl/inflight_line_tracker.sv
module inflight_line_tracker
    import trk_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFF_W   = 6,
    parameter int ENTRIES = 4,
    parameter int MAX_OUT = 6,
    parameter int THRESH  = 32,
    parameter int CNT_W   = 16,
    localparam int LINE_W = ADDR_W - OFF_W,
    localparam int TS_W   = $clog2(THRESH) + 2,
    localparam int TCW    = $clog2(ENTRIES + 1),
    localparam int OCC_W  = $clog2(2 * ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              rd_done_valid,
    input  logic [ADDR_W-1:0] rd_done_addr,
    input  logic              wr_done_valid,
    input  logic [ADDR_W-1:0] wr_done_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [OCC_W-1:0]  outstanding,
    output logic              deadlock,
    output logic              proto_err,
    output logic [CNT_W-1:0]  alias_st_ld,
    output logic [CNT_W-1:0]  alias_st_st,
    output logic [CNT_W-1:0]  alias_ld_st,
    output logic [CNT_W-1:0]  alias_ld_ld
);

    typedef struct packed {
        logic             rsp_valid;
        logic [1:0]       rsp_status;
        logic             proto_err;
        logic [TS_W-1:0]  now;
        logic [CNT_W-1:0] st_ld;
        logic [CNT_W-1:0] st_st;
        logic [CNT_W-1:0] ld_st;
        logic [CNT_W-1:0] ld_ld;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [LINE_W-1:0] req_line, rd_line, wr_line;
    logic              is_wr;
    logic              rd_hit, wr_hit, rd_miss, wr_miss;
    logic              rd_slot, wr_slot;
    logic [TCW-1:0]    rd_occ, wr_occ, rd_post, wr_post;
    logic [ENTRIES-1:0]            rd_live, wr_live;
    logic [ENTRIES-1:0][TS_W-1:0]  rd_stamp, wr_stamp;
    logic [OCC_W-1:0]  post_total;
    logic              full;
    logic              rd_alloc, wr_alloc, accept;
    logic              unused_offsets;

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign rd_line  = rd_done_addr[ADDR_W-1:OFF_W];
    assign wr_line  = wr_done_addr[ADDR_W-1:OFF_W];
    assign unused_offsets = ^{req_addr[OFF_W-1:0], rd_done_addr[OFF_W-1:0],
                              wr_done_addr[OFF_W-1:0]};
    assign is_wr    = kind_is_write(req_kind);

    trk_table #(.N(ENTRIES), .LW(LINE_W), .TW(TS_W)) u_rd_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .now_i        (st_q.now),
        .look_line_i  (req_line),
        .look_hit_o   (rd_hit),
        .free_valid_i (rd_done_valid),
        .free_line_i  (rd_line),
        .free_miss_o  (rd_miss),
        .alloc_i      (rd_alloc),
        .has_slot_o   (rd_slot),
        .occ_o        (rd_occ),
        .post_occ_o   (rd_post),
        .live_o       (rd_live),
        .stamp_o      (rd_stamp)
    );

    trk_table #(.N(ENTRIES), .LW(LINE_W), .TW(TS_W)) u_wr_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .now_i        (st_q.now),
        .look_line_i  (req_line),
        .look_hit_o   (wr_hit),
        .free_valid_i (wr_done_valid),
        .free_line_i  (wr_line),
        .free_miss_o  (wr_miss),
        .alloc_i      (wr_alloc),
        .has_slot_o   (wr_slot),
        .occ_o        (wr_occ),
        .post_occ_o   (wr_post),
        .live_o       (wr_live),
        .stamp_o      (wr_stamp)
    );

    assign post_total = OCC_W'(rd_post) + OCC_W'(wr_post);
    assign full       = (post_total >= OCC_W'(MAX_OUT)) ||
                        (is_wr ? !wr_slot : !rd_slot);

    always_comb begin
        st_d            = st_q;
        st_d.now        = st_q.now + TS_W'(1);
        st_d.rsp_valid  = req_valid;
        st_d.rsp_status = RSP_ACCEPT;
        rd_alloc        = 1'b0;
        wr_alloc        = 1'b0;

        if (rd_miss || wr_miss) begin
            st_d.proto_err = 1'b1;
        end

        if (req_valid) begin
            if (full) begin
                st_d.rsp_status = RSP_FULL;
            end else if (is_wr) begin
                // Opposite-class table is consulted first.
                if (rd_hit) begin
                    st_d.rsp_status = RSP_ALIAS;
                    st_d.st_ld      = st_q.st_ld + CNT_W'(1);
                end else if (wr_hit) begin
                    st_d.rsp_status = RSP_ALIAS;
                    st_d.st_st      = st_q.st_st + CNT_W'(1);
                end else begin
                    wr_alloc = 1'b1;
                end
            end else begin
                if (wr_hit) begin
                    st_d.rsp_status = RSP_ALIAS;
                    st_d.ld_st      = st_q.ld_st + CNT_W'(1);
                end else if (rd_hit) begin
                    st_d.rsp_status = RSP_ALIAS;
                    st_d.ld_ld      = st_q.ld_ld + CNT_W'(1);
                end else begin
                    rd_alloc = 1'b1;
                end
            end
        end
    end

    assign accept = rd_alloc || wr_alloc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    trk_watchdog #(.M(2 * ENTRIES), .TW(TS_W), .THRESH(THRESH)) u_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .now_i       (st_q.now),
        .live_i      ({wr_live, rd_live}),
        .stamp_i     ({wr_stamp, rd_stamp}),
        .arm_i       (accept),
        .busy_next_i ((post_total != '0) || accept),
        .deadlock_o  (deadlock)
    );

    assign rsp_valid   = st_q.rsp_valid;
    assign rsp_status  = st_q.rsp_status;
    assign outstanding = OCC_W'(rd_occ) + OCC_W'(wr_occ);
    assign proto_err   = st_q.proto_err;
    assign alias_st_ld = st_q.st_ld;
    assign alias_st_st = st_q.st_st;
    assign alias_ld_st = st_q.ld_st;
    assign alias_ld_ld = st_q.ld_ld;

endmodule

// File: rtl/inflight_line_tracker_chk.sv
module inflight_line_tracker_chk #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 4,
    parameter int MAX_OUT = 6,
    parameter int CNT_W   = 16,
    localparam int OCC_W  = $clog2(2 * ENTRIES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              rd_done_valid,
    input logic              wr_done_valid,
    input logic              rsp_valid,
    input logic [1:0]        rsp_status,
    input logic [OCC_W-1:0]  outstanding,
    input logic              deadlock,
    input logic              proto_err,
    input logic [CNT_W-1:0]  alias_st_ld,
    input logic [CNT_W-1:0]  alias_st_st,
    input logic [CNT_W-1:0]  alias_ld_st,
    input logic [CNT_W-1:0]  alias_ld_ld
);

    p_rsp_follows_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_count_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(outstanding) <= MAX_OUT);

    p_full_at_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(outstanding) == MAX_OUT && !rd_done_valid && !wr_done_valid)
        |=> rsp_status == 2'd2);

    p_accept_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd0 && !$past(rd_done_valid) && !$past(wr_done_valid))
        |-> outstanding == OCC_W'($past(outstanding) + 1'b1));

    p_deadlock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        deadlock |=> deadlock);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    p_counters_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_status == 2'd1)
        |-> ($stable(alias_st_ld) && $stable(alias_st_st) &&
             $stable(alias_ld_st) && $stable(alias_ld_ld)));

    p_one_counter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'd1)
        |-> $countones({alias_st_ld != $past(alias_st_ld), alias_st_st != $past(alias_st_st),
                        alias_ld_st != $past(alias_ld_st), alias_ld_ld != $past(alias_ld_ld)}) == 1);

endmodule

bind inflight_line_tracker inflight_line_tracker_chk #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES),
    .MAX_OUT (MAX_OUT),
    .CNT_W   (CNT_W)
) u_chk (.*);

// File: tb/inflight_line_tracker_test.sv
`timescale 1ns/1ps
module inflight_line_tracker_test;

    localparam int TH   = 32;
    localparam int OCCW = 4;

    localparam logic [2:0] LOAD = 3'd0, IFETCH = 3'd1, STORE = 3'd2, RMW = 3'd3,
                           LL = 3'd4, SC = 3'd5, FLUSH = 3'd7;
    localparam logic [1:0] ACC = 2'd0, ALI = 2'd1, FUL = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [31:0] req_addr = '0;
    logic        rd_done_valid = 1'b0;
    logic [31:0] rd_done_addr = '0;
    logic        wr_done_valid = 1'b0;
    logic [31:0] wr_done_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [OCCW-1:0] outstanding;
    logic        deadlock, proto_err;
    logic [15:0] alias_st_ld, alias_st_st, alias_ld_st, alias_ld_ld;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    inflight_line_tracker #(.ADDR_W(32), .OFF_W(6), .ENTRIES(4), .MAX_OUT(6),
                            .THRESH(TH), .CNT_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .rd_done_valid(rd_done_valid), .rd_done_addr(rd_done_addr),
        .wr_done_valid(wr_done_valid), .wr_done_addr(wr_done_addr),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .outstanding(outstanding),
        .deadlock(deadlock), .proto_err(proto_err), .alias_st_ld(alias_st_ld),
        .alias_st_st(alias_st_st), .alias_ld_st(alias_ld_st), .alias_ld_ld(alias_ld_ld)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a response appears.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R7 unexpected response: actual %0d expected none", rsp_status);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "rsp_status", 32'(rsp_status), 32'(e));
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        rd_done_valid = 1'b0;
        wr_done_valid = 1'b0;
        exp_q.delete();
        tag_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [2:0] k, input logic [31:0] a,
                        input logic [1:0] exp, input string rq);
        req_valid = 1'b1;
        req_kind  = k;
        req_addr  = a;
        exp_q.push_back(exp);
        tag_q.push_back(rq);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_with_rd_done(input logic [2:0] k, input logic [31:0] a,
                                     input logic [31:0] da, input logic [1:0] exp,
                                     input string rq);
        rd_done_valid = 1'b1;
        rd_done_addr  = da;
        send(k, a, exp, rq);
        rd_done_valid = 1'b0;
    endtask

    task automatic rd_done(input logic [31:0] a);
        rd_done_valid = 1'b1;
        rd_done_addr  = a;
        @(negedge clk);
        rd_done_valid = 1'b0;
    endtask

    task automatic wr_done(input logic [31:0] a);
        wr_done_valid = 1'b1;
        wr_done_addr  = a;
        @(negedge clk);
        wr_done_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();

        // Reset state (R7, R8, R10, R11)
        check("R8", "outstanding at reset", 32'(outstanding), 0);
        check("R7", "rsp_valid at reset", 32'(rsp_valid), 0);
        check("R11", "deadlock at reset", 32'(deadlock), 0);
        check("R10", "proto_err at reset", 32'(proto_err), 0);

        // Read-class routing, offset masking
        send(LOAD,   32'h0000_1000, ACC, "R2");
        send(IFETCH, 32'h0000_2000, ACC, "R2");
        send(LOAD,   32'h0000_1020, ALI, "R6");
        send(LOAD,   32'h0000_1040, ACC, "R6");
        check("R8", "outstanding after 3 reads", 32'(outstanding), 3);
        check("R5", "load-after-load count", 32'(alias_ld_ld), 1);

        // Cross-table checks
        send(STORE, 32'h0000_1000, ALI, "R3");
        send(FLUSH, 32'h0000_3000, ACC, "R2");
        send(SC,    32'h0000_3010, ALI, "R3");
        send(LOAD,  32'h0000_3000, ALI, "R4");
        check("R5", "store-after-load count", 32'(alias_st_ld), 1);
        check("R5", "store-after-store count", 32'(alias_st_st), 1);
        check("R5", "load-after-store count", 32'(alias_ld_st), 1);
        check("R5", "load-after-load unchanged", 32'(alias_ld_ld), 1);
        check("R8", "outstanding 4", 32'(outstanding), 4);

        // Read table full below the count limit
        send(LOAD, 32'h0000_5000, ACC, "R4");
        send(LOAD, 32'h0000_6000, FUL, "R1");
        check("R1", "no alias count on full", 32'(alias_ld_ld), 1);

        // Count limit; full outranks alias
        send(RMW,   32'h0000_7000, ACC, "R2");
        send(STORE, 32'h0000_8000, FUL, "R1");
        send(STORE, 32'h0000_1000, FUL, "R1");
        check("R1", "store-after-load unchanged on full", 32'(alias_st_ld), 1);
        check("R1", "outstanding at limit", 32'(outstanding), 6);

        // Completion first, then insert
        send_with_rd_done(LL, 32'h0000_9000, 32'h0000_1000, ACC, "R9");
        check("R9", "outstanding after swap", 32'(outstanding), 6);

        // Unmatched completion
        check("R10", "proto_err before", 32'(proto_err), 0);
        wr_done(32'h0000_A000);
        check("R10", "proto_err set", 32'(proto_err), 1);
        check("R10", "outstanding unchanged", 32'(outstanding), 6);

        // Matched completion frees and line is reusable
        wr_done(32'h0000_3000);
        check("R8", "outstanding after free", 32'(outstanding), 5);
        send(LOAD, 32'h0000_3010, ACC, "R8");
        check("R8", "outstanding after reuse", 32'(outstanding), 6);
        check("R10", "proto_err holds", 32'(proto_err), 1);

        // No deadlock when work completes early
        do_reset();
        send(LOAD, 32'h0000_4000, ACC, "R12");
        repeat (3) @(negedge clk);
        rd_done(32'h0000_4000);
        repeat (3 * TH) @(negedge clk);
        check("R12", "deadlock stays low", 32'(deadlock), 0);
        check("R12", "outstanding empty", 32'(outstanding), 0);

        // Exact firing edge for a stuck entry
        do_reset();
        send(STORE, 32'h0000_4400, ACC, "R11");
        repeat (TH - 1) @(negedge clk);
        check("R11", "deadlock one cycle early", 32'(deadlock), 0);
        @(negedge clk);
        check("R11", "deadlock at threshold", 32'(deadlock), 1);

        // Entry inserted after arming is caught by the second check
        do_reset();
        send(LOAD, 32'h0000_4800, ACC, "R11");
        repeat (4) @(negedge clk);
        rd_done(32'h0000_4800);
        send(LOAD, 32'h0000_4C00, ACC, "R11");
        repeat (2 * TH - 7) @(negedge clk);
        check("R11", "deadlock before second check", 32'(deadlock), 0);
        @(negedge clk);
        check("R11", "deadlock at second check", 32'(deadlock), 1);

        repeat (2) @(negedge clk);
        check("R7", "all responses seen", 32'(exp_q.size()), 0);
        finish_run();
    end

endmodule